// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

A 32-bit processor that fetches, decodes, executes and retires one instruction per clock. It runs a small instruction set: word load, word store, branch-if-equal, and five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than). Instruction memory, data memory and a 32-entry register file are all inside the block. A testbench or the surrounding system fills both memories before reset is released.

A purely combinational decoder looks only at the opcode field. It drives the register destination select, the second-operand select, the writeback select, the register write enable, the memory read and write enables, a branch flag and a 2-bit ALU operation class. A second small decoder turns that class, plus the function field for register operations, into the 3-bit ALU operation. The next PC is the branch target only when the branch flag is set and the ALU result is zero.

The ports carry the current PC, the fetched instruction, the register writeback (enable, address, data) and the data store (enable, address, data). These are enough to follow every architectural effect from outside.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and every register reads as 0. After release, the first instruction comes from address 0.
- R2: Every instruction except a taken branch leaves pc_o one word higher (+4) on the next cycle. instr_o always shows the instruction word at pc_o.
- R3: Opcode 000000 is a register operation. Function code 100000 adds, 100010 subtracts, 100100 is bitwise and, 100101 is bitwise or, and 101010 yields 1 when rs is below rt as signed values (else 0). The result goes to register rd (bits 15:11), shown on rf_we_o, rf_waddr_o and rf_wdata_o.
- R4: Opcode 100011 loads the data-memory word at rs plus the sign-extended 16-bit immediate into register rt (bits 20:16). rf_wdata_o shows the memory word.
- R5: Opcode 101011 stores register rt to the data-memory word at rs plus the sign-extended immediate. dm_we_o is high, dm_addr_o and dm_wdata_o show the address and data, and rf_we_o is low.
- R6: Opcode 000100 writes nothing. When rs equals rt, the next PC is PC+4 plus the sign-extended immediate shifted left by two; otherwise it is PC+4.
- R7: Register 0 always reads as 0. A register operation that targets it leaves it at 0, seen when it is later stored.
- R8: Any other opcode writes no register, stores nothing and advances the PC by 4.
- R9: A store takes effect at the rising edge. A load from the same word in the following cycle returns the stored data, because memory reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction fetched at pc_o |
| rf_we_o | output | 1 | Register write enable this cycle |
| rf_waddr_o | output | 5 | Register write address |
| rf_wdata_o | output | 32 | Register write data |
| dm_we_o | output | 1 | Data-memory store enable this cycle |
| dm_addr_o | output | 32 | Data-memory byte address (ALU result) |
| dm_wdata_o | output | 32 | Data-memory store data |

## Verification
The bench uses the default sizes of 64 words for both instruction and data memory. With arrays this small, random base registers and immediates often alias onto the same data word, and random branch offsets wrap the PC around the instruction array. Store-then-load hazards and taken backward branches therefore happen often, not rarely. A seeded random program runs after a directed prefix that covers each operation, writes to register 0 and both branch outcomes. A mid-run reset is included so that register clearing and restart at address 0 are also reached.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  typedef enum logic [5:0] {
    OP_REG   = 6'b000000,
    OP_BEQ   = 6'b000100,
    OP_LOAD  = 6'b100011,
    OP_STORE = 6'b101011
  } opcode_e;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_REG    = 2'b10
  } alu_class_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_sel_e;

  typedef struct packed {
    logic       dst_rd;
    logic       opb_imm;
    logic       wb_mem;
    logic       rf_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       is_branch;
    alu_class_e alu_class;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  output ctrl_t      ctrl_o
);
  // don't-care selects are pinned to 0 to keep simulation deterministic
  always_comb begin
    ctrl_o           = '0;
    ctrl_o.alu_class = CLS_MEM;
    case (op_i)
      OP_REG: begin
        ctrl_o.dst_rd    = 1'b1;
        ctrl_o.rf_wr     = 1'b1;
        ctrl_o.alu_class = CLS_REG;
      end
      OP_LOAD: begin
        ctrl_o.opb_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
        ctrl_o.rf_wr   = 1'b1;
        ctrl_o.mem_rd  = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.opb_imm = 1'b1;
        ctrl_o.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.is_branch = 1'b1;
        ctrl_o.alu_class = CLS_BRANCH;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_class_e     class_i,
  input  logic [5:0]     funct_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic           zero_o
);
  alu_sel_e sel;

  // second control level: class plus function field
  always_comb begin
    case (class_i)
      CLS_MEM:    sel = ALU_ADD;
      CLS_BRANCH: sel = ALU_SUB;
      CLS_REG: begin
        case (funct_i)
          FN_ADD:  sel = ALU_ADD;
          FN_SUB:  sel = ALU_SUB;
          FN_AND:  sel = ALU_AND;
          FN_OR:   sel = ALU_OR;
          FN_SLT:  sel = ALU_SLT;
          default: sel = ALU_ADD;
        endcase
      end
      default:    sel = ALU_ADD;
    endcase
  end

  always_comb begin
    case (sel)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  rda_o,
  output logic [W-1:0]  rdb_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  localparam int NREGS = 1 << AW;

  logic [W-1:0] regs [NREGS];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs[g] <= '0;
      else if (we_i && (wa_i == AW'(g)))    regs[g] <= wd_i;
    end
  end

  assign rda_o = regs[ra_i];
  assign rdb_o = regs[rb_i];
endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int W  = 32,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic          re_i,
  output logic [W-1:0]  rdata_o,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = re_i ? mem_q[addr_i] : '0;
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);
  logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_target;
  logic [XLEN-1:0]   instr, imm_ext, rs_val, rt_val, opb, alu_res, dm_rdata;
  logic [REG_AW-1:0] waddr;
  logic              alu_zero, take_br;
  ctrl_t             ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  sc_ram #(.W(XLEN), .AW(IMEM_AW)) u_imem (
    .clk_i   (clk_i),
    .addr_i  (pc_q[IMEM_AW+1:2]),
    .re_i    (1'b1),
    .rdata_o (instr),
    .we_i    (1'b0),
    .wdata_i ('0)
  );

  sc_decoder u_dec (
    .op_i   (instr[31:26]),
    .ctrl_o (ctrl)
  );

  assign waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (instr[25:21]),
    .rb_i   (instr[20:16]),
    .rda_o  (rs_val),
    .rdb_o  (rt_val),
    .we_i   (ctrl.rf_wr),
    .wa_i   (waddr),
    .wd_i   (rf_wdata_o)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign opb     = ctrl.opb_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .class_i (ctrl.alu_class),
    .funct_i (instr[5:0]),
    .a_i     (rs_val),
    .b_i     (opb),
    .res_o   (alu_res),
    .zero_o  (alu_zero)
  );

  sc_ram #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk_i   (clk_i),
    .addr_i  (alu_res[DMEM_AW+1:2]),
    .re_i    (ctrl.mem_rd),
    .rdata_o (dm_rdata),
    .we_i    (ctrl.mem_wr),
    .wdata_i (rt_val)
  );

  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign take_br   = ctrl.is_branch & alu_zero;
  assign pc_next   = take_br ? br_target : pc_plus4;

  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign rf_we_o    = ctrl.rf_wr;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = ctrl.wb_mem ? dm_rdata : alu_res;
  assign dm_we_o    = ctrl.mem_wr;
  assign dm_addr_o  = alu_res;
  assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic [31:0] rf_wdata_o,
  input logic        dm_we_o,
  input logic [31:0] dm_addr_o,
  input logic [31:0] dm_wdata_o
);
  logic [5:0] op;
  logic       op_known;
  assign op       = instr_o[31:26];
  assign op_known = (op == OP_REG) || (op == OP_BEQ) || (op == OP_LOAD) || (op == OP_STORE);

  p_reset_pc_r1: assert property (@(posedge clk_i) !rst_ni |-> pc_o == 32'd0);

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BEQ) |=> pc_o == $past(pc_o) + 32'd4);

  p_reg_dest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_REG) |-> rf_we_o && rf_waddr_o == instr_o[15:11] && !dm_we_o);

  p_load_dest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_LOAD) |-> rf_we_o && rf_waddr_o == instr_o[20:16] && !dm_we_o);

  p_store_no_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we_o |-> !rf_we_o && op == OP_STORE);

  p_branch_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ) |-> !rf_we_o && !dm_we_o);

  p_unknown_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_known |-> !rf_we_o && !dm_we_o);
endmodule

bind sc_core sc_core_chk u_chk (.*);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
  localparam int IAW = 6;
  localparam int DAW = 6;

  logic        clk, rst_n;
  logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] im [1<<IAW];
  logic [31:0] dm [1<<DAW];
  logic [31:0] rf [32];
  logic [31:0] mpc;
  string       pc_tag;
  bit          last_sw_v;
  logic [31:0] last_sw_addr;

  sc_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pc_o(pc_o), .instr_o(instr_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] r_ins(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction

  function automatic logic [31:0] i_ins(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] sext(logic [15:0] imm);
    return {{16{imm[15]}}, imm};
  endfunction

  function automatic logic [31:0] rand_ins();
    logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    logic [4:0] rs = 5'($urandom % 12);
    logic [4:0] rt = 5'($urandom % 12);
    logic [4:0] rd = 5'($urandom % 12);
    logic [15:0] mimm = 16'($signed(8'($urandom)));
    logic [15:0] boff = 16'(int'($urandom % 13) - 6);
    logic [5:0] op;
    int k = int'($urandom % 10);
    if (k < 5) return r_ins(fns[k], rs, rt, rd);
    if (k == 5) return i_ins(6'h23, rs, rt, mimm);
    if (k == 6) return i_ins(6'h2B, rs, rt, mimm);
    if (k == 7) return i_ins(6'h04, rs, rt, boff);
    if (k == 8) return i_ins(6'h04, rs, rs, boff);
    op = 6'($urandom);
    while (op == 6'h00 || op == 6'h04 || op == 6'h23 || op == 6'h2B) op = 6'($urandom);
    return i_ins(op, rs, rt, mimm);
  endfunction

  function automatic logic [31:0] ref_alu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'h20:   return a + b;
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  // check one instruction at a falling edge, then advance the model
  task automatic step();
    logic [31:0] ins  = im[mpc[IAW+1:2]];
    logic [5:0]  op   = ins[31:26];
    logic [4:0]  rs   = ins[25:21];
    logic [4:0]  rt   = ins[20:16];
    logic [4:0]  rd   = ins[15:11];
    logic [31:0] rsv  = rf[rs];
    logic [31:0] rtv  = rf[rt];
    logic [31:0] addr = rsv + sext(ins[15:0]);
    logic [31:0] res;
    logic [31:0] npc  = mpc + 32'd4;
    bit          sw_now = 0;
    chk(pc_tag, pc_o, mpc);
    chk("R2 fetch", instr_o, ins);
    case (op)
      6'h00: begin
        res = ref_alu(ins[5:0], rsv, rtv);
        chk("R3 we", {31'b0, rf_we_o}, 32'd1);
        chk("R3 waddr", {27'b0, rf_waddr_o}, {27'b0, rd});
        chk("R3 wdata", rf_wdata_o, res);
        chk("R3 no store", {31'b0, dm_we_o}, 32'd0);
        if (rd != 0) rf[rd] = res;
      end
      6'h23: begin
        res = dm[addr[DAW+1:2]];
        chk("R4 we", {31'b0, rf_we_o}, 32'd1);
        chk("R4 waddr", {27'b0, rf_waddr_o}, {27'b0, rt});
        chk((last_sw_v && last_sw_addr[DAW+1:2] == addr[DAW+1:2]) ? "R9 load after store" : "R4 wdata",
            rf_wdata_o, res);
        chk("R4 no store", {31'b0, dm_we_o}, 32'd0);
        if (rt != 0) rf[rt] = res;
      end
      6'h2B: begin
        chk("R5 store en", {31'b0, dm_we_o}, 32'd1);
        chk("R5 addr", dm_addr_o, addr);
        chk(rt == 0 ? "R7 zero store" : "R5 data", dm_wdata_o, rtv);
        chk("R5 no wb", {31'b0, rf_we_o}, 32'd0);
        dm[addr[DAW+1:2]] = rtv;
        sw_now = 1;
        last_sw_addr = addr;
      end
      6'h04: begin
        chk("R6 no wb", {31'b0, rf_we_o}, 32'd0);
        chk("R6 no store", {31'b0, dm_we_o}, 32'd0);
        if (rsv == rtv) npc = mpc + 32'd4 + {sext(ins[15:0]), 2'b00}[31:0];
      end
      default: begin
        chk("R8 no wb", {31'b0, rf_we_o}, 32'd0);
        chk("R8 no store", {31'b0, dm_we_o}, 32'd0);
      end
    endcase
    last_sw_v = sw_now;
    pc_tag = (op == 6'h04) ? "R6 next pc" : "R2 next pc";
    mpc = npc;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) rf[i] = '0;
    mpc = '0;
    pc_tag = "R1 start";
    last_sw_v = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0;
    for (int i = 0; i < (1 << IAW); i++) im[i] = rand_ins();
    for (int i = 0; i < (1 << DAW); i++) dm[i] = $urandom;
    dm[0] = 32'd5;
    dm[1] = 32'hFFFF_FFFD;
    im[0]  = i_ins(6'h23, 0, 1, 16'd0);
    im[1]  = i_ins(6'h23, 0, 2, 16'd4);
    im[2]  = r_ins(6'h20, 1, 2, 3);
    im[3]  = r_ins(6'h22, 1, 2, 4);
    im[4]  = r_ins(6'h2A, 2, 1, 5);
    im[5]  = r_ins(6'h2A, 1, 2, 6);
    im[6]  = r_ins(6'h24, 1, 2, 7);
    im[7]  = r_ins(6'h25, 1, 2, 8);
    im[8]  = r_ins(6'h20, 1, 1, 0);
    im[9]  = i_ins(6'h2B, 0, 0, 16'd8);
    im[10] = i_ins(6'h2B, 0, 3, 16'd12);
    im[11] = i_ins(6'h23, 0, 9, 16'd12);
    im[12] = i_ins(6'h04, 1, 1, 16'd1);
    im[13] = r_ins(6'h20, 1, 1, 10);
    im[14] = i_ins(6'h04, 1, 2, 16'd5);
    im[15] = i_ins(6'h3F, 1, 2, 16'd0);
    for (int i = 0; i < (1 << IAW); i++) u_dut.u_imem.mem_q[i] = im[i];
    for (int i = 0; i < (1 << DAW); i++) u_dut.u_dmem.mem_q[i] = dm[i];
    model_reset();

    repeat (3) begin
      @(negedge clk);
      chk("R1 pc in reset", pc_o, 32'd0);
    end
    rst_n = 1'b1;
    for (int c = 0; c < 400; c++) begin
      step();
      @(negedge clk);
    end

    // mid-run reset: registers clear, data memory keeps its contents
    rst_n = 1'b0;
    #1;
    chk("R1 async pc clear", pc_o, 32'd0);
    model_reset();
    @(negedge clk);
    chk("R1 pc held", pc_o, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < 400; c++) begin
      step();
      @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule